// File: doc/BRIEF.md
# Microcoded Register-Transfer Processor

This block is a small 16-bit processor whose every control signal comes out of a constant control memory. A microprogram counter selects one microword per cycle. Each microword carries a register write enable, an ALU function, a fetch strobe, an instruction-latch strobe, a dispatch flag and a next-address field. The datapath has sixteen general registers, a program counter, an instruction register holding the two register fields, and an ALU that can pass, add or AND.

Three instructions exist: move, add and bitwise AND, all register to register. Instructions are read from a synchronous instruction memory, which returns data one cycle after the read strobe. The decode microstep latches the returned word and jumps straight to the matching execute microstep. Each execute microstep also issues the read of the next instruction. Fetch of instruction n+1 therefore overlaps execution of instruction n, and in steady state one instruction retires every two cycles. Any opcode outside the three defined ones stops the machine until reset.

Because the instruction set has no load, each register resets to its own seed value so that programs have operands. A combinational debug port reads any register.

Top module: `ucpu_top`

## Requirements
- R1: While reset (rst_n low, asynchronous) is held, imem_addr is 0, imem_rd is 1 and halted is 0. Register k holds INIT_BASE + k*INIT_STRIDE modulo 2^16, which is 0x0005 + k*0x0123 with the defaults.
- R2: An instruction word carries the opcode in bits 15:8, the destination register Ry in bits 7:4 and the source register Rx in bits 3:0.
- R3: Opcode 0x01 (move) writes Rx into Ry.
- R4: Opcode 0x02 (add) writes (Ry + Rx) modulo 2^16 into Ry.
- R5: Opcode 0x03 (and) writes Ry bitwise-AND Rx into Ry.
- R6: A fetch reads the instruction memory at the program counter, with imem_rd high for that one cycle. It then advances the program counter by 2. The memory returns the word on imem_rdata in the following cycle.
- R7: The first rising edge after reset is released performs the first fetch. Every instruction then takes exactly two cycles, decode and execute, and the execute cycle also fetches the next word. With N valid instructions followed by an invalid one, halted first reads 1 after rising edge 2N+2, and imem_addr is then 2(N+1). A fetch is never followed directly by another fetch or by a register write.
- R8: A register write takes effect at the edge that ends the execute cycle, so the next instruction reads the updated value.
- R9: Any opcode other than 0x01, 0x02 and 0x03 sends the machine to a halt state. In that state halted is 1, imem_rd stays 0, and imem_addr and all registers keep their values until reset.
- R10: dbg_data combinationally shows the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction memory byte address (program counter) |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_rdata | input | 16 | Instruction word, valid the cycle after imem_rd |
| dbg_sel | input | 4 | Register index for the debug port |
| dbg_data | output | 16 | Contents of the selected register |
| halted | output | 1 | High once an unknown opcode has been decoded |

## Verification
The properties assume that the instruction memory behaves as a registered read. The word for the address presented with imem_rd must appear on imem_rdata in the next cycle, because decode dispatches on imem_rdata directly and has no valid signal to wait on. The bench models the memory exactly this way, as a 64-word array read on the clock edge. It keeps every program shorter than that array and fills unused words with an invalid opcode, so each run ends in the halt state within a bounded number of cycles. Random programs draw only the three defined opcodes. Invalid opcodes appear only where a directed case places them deliberately.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

  localparam int WORD_W  = 16;
  localparam int OP_W    = 8;
  localparam int RIDX_W  = 4;
  localparam int NUM_REG = 1 << RIDX_W;
  localparam int UPC_W   = 3;

  // instruction layout: [15:8] opcode, [7:4] destination, [3:0] source
  localparam int OP_LSB  = 8;
  localparam int RY_LSB  = 4;
  localparam int RX_LSB  = 0;

  localparam logic [OP_W-1:0] OP_MOV = 8'h01;
  localparam logic [OP_W-1:0] OP_ADD = 8'h02;
  localparam logic [OP_W-1:0] OP_AND = 8'h03;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_SUM  = 2'd1,
    ALU_MASK = 2'd2,
    ALU_ZERO = 2'd3
  } alu_fn_e;

  typedef enum logic [UPC_W-1:0] {
    US_FETCH  = 3'd0,
    US_DECODE = 3'd1,
    US_MOV    = 3'd2,
    US_ADD    = 3'd3,
    US_AND    = 3'd4,
    US_HALT   = 3'd5
  } ustep_e;

  typedef struct packed {
    logic    wr_y;      // write ALU result into Ry
    alu_fn_e alu_fn;    // ALU operation
    logic    fetch;     // read memory at PC, PC += step
    logic    ld_ir;     // latch register fields of the returned word
    logic    dispatch;  // next address comes from the opcode map
    ustep_e  next;      // next address when not dispatching
  } uword_t;

  function automatic logic [WORD_W-1:0] alu_calc(alu_fn_e fn,
                                                 logic [WORD_W-1:0] a,
                                                 logic [WORD_W-1:0] b);
    case (fn)
      ALU_PASS: return b;
      ALU_SUM:  return a + b;
      ALU_MASK: return a & b;
      default:  return '0;
    endcase
  endfunction

  function automatic ustep_e op_map(logic [OP_W-1:0] op);
    case (op)
      OP_MOV:  return US_MOV;
      OP_ADD:  return US_ADD;
      OP_AND:  return US_AND;
      default: return US_HALT;
    endcase
  endfunction

  function automatic uword_t exec_word(alu_fn_e fn);
    uword_t w;
    w.wr_y     = 1'b1;
    w.alu_fn   = fn;
    w.fetch    = 1'b1;
    w.ld_ir    = 1'b0;
    w.dispatch = 1'b0;
    w.next     = US_DECODE;
    return w;
  endfunction

  // control memory contents, one word per microprogram address
  function automatic uword_t urom(ustep_e a);
    uword_t w;
    w.wr_y     = 1'b0;
    w.alu_fn   = ALU_ZERO;
    w.fetch    = 1'b0;
    w.ld_ir    = 1'b0;
    w.dispatch = 1'b0;
    w.next     = US_HALT;
    case (a)
      US_FETCH: begin
        w.fetch = 1'b1;
        w.next  = US_DECODE;
      end
      US_DECODE: begin
        w.ld_ir    = 1'b1;
        w.dispatch = 1'b1;
      end
      US_MOV:  w = exec_word(ALU_PASS);
      US_ADD:  w = exec_word(ALU_SUM);
      US_AND:  w = exec_word(ALU_MASK);
      default: w.next = US_HALT;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ucpu_ctrl_rom.sv
module ucpu_ctrl_rom
  import ucpu_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  ustep_e addr,
  output uword_t uw
);
  localparam int DEPTH = 1 << AW;

  uword_t table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_q[i] = urom(ustep_e'(i));
  end

  assign uw = table_q[addr];
endmodule

// File: rtl/ucpu_seq.sv
module ucpu_seq
  import ucpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  uword_t          uw,
  input  logic [OP_W-1:0] opcode,
  output ustep_e          upc
);
  ustep_e upc_q;
  ustep_e upc_nxt;

  always_comb begin
    if (uw.dispatch) upc_nxt = op_map(opcode);
    else             upc_nxt = uw.next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= US_FETCH;
    else        upc_q <= upc_nxt;
  end

  assign upc = upc_q;
endmodule

// File: rtl/ucpu_regfile.sv
module ucpu_regfile #(
  parameter int          W      = 16,
  parameter int          N      = 16,
  parameter logic [15:0] BASE   = 16'h0005,
  parameter logic [15:0] STRIDE = 16'h0123,
  localparam int         AW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_y,
  input  logic [AW-1:0] raddr_x,
  output logic [W-1:0]  rdata_y,
  output logic [W-1:0]  rdata_x,
  input  logic [AW-1:0] dbg_sel,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] regs_q [N];

  for (genvar k = 0; k < N; k++) begin : g_reg
    localparam logic [W-1:0] SEED = W'(BASE + k * STRIDE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs_q[k] <= SEED;
      else if (we && (waddr == AW'(k)))        regs_q[k] <= wdata;
    end
  end

  assign rdata_y  = regs_q[raddr_y];
  assign rdata_x  = regs_q[raddr_x];
  assign dbg_data = regs_q[dbg_sel];
endmodule

// File: rtl/ucpu_alu.sv
module ucpu_alu
  import ucpu_pkg::*;
(
  input  alu_fn_e           fn,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y
);
  assign y = alu_calc(fn, a, b);
endmodule

// File: rtl/ucpu_top.sv
module ucpu_top
  import ucpu_pkg::*;
#(
  parameter logic [15:0] INIT_BASE   = 16'h0005,
  parameter logic [15:0] INIT_STRIDE = 16'h0123,
  parameter logic [15:0] PC_STEP     = 16'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] imem_addr,
  output logic        imem_rd,
  input  logic [15:0] imem_rdata,
  input  logic [3:0]  dbg_sel,
  output logic [15:0] dbg_data,
  output logic        halted
);
  localparam int FLD_W = 2 * RIDX_W;

  ustep_e              upc;
  uword_t              uw;
  logic [WORD_W-1:0]   pc_q;
  logic [FLD_W-1:0]    ir_q;
  logic [RIDX_W-1:0]   ry, rx;
  logic [WORD_W-1:0]   opnd_y, opnd_x, alu_y;

  // named control events, observed by the checker
  logic fetch_go;
  logic rf_we;
  logic ir_load;

  assign fetch_go = uw.fetch;
  assign rf_we    = uw.wr_y;
  assign ir_load  = uw.ld_ir;

  ucpu_ctrl_rom #(.AW(UPC_W)) u_rom (
    .addr (upc),
    .uw   (uw)
  );

  ucpu_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .uw     (uw),
    .opcode (imem_rdata[OP_LSB +: OP_W]),
    .upc    (upc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (fetch_go) pc_q <= pc_q + PC_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= '0;
    else if (ir_load) ir_q <= imem_rdata[FLD_W-1:0];
  end

  assign ry = ir_q[RY_LSB +: RIDX_W];
  assign rx = ir_q[RX_LSB +: RIDX_W];

  ucpu_regfile #(
    .W      (WORD_W),
    .N      (NUM_REG),
    .BASE   (INIT_BASE),
    .STRIDE (INIT_STRIDE)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rf_we),
    .waddr    (ry),
    .wdata    (alu_y),
    .raddr_y  (ry),
    .raddr_x  (rx),
    .rdata_y  (opnd_y),
    .rdata_x  (opnd_x),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
  );

  ucpu_alu u_alu (
    .fn (uw.alu_fn),
    .a  (opnd_y),
    .b  (opnd_x),
    .y  (alu_y)
  );

  assign imem_addr = pc_q;
  assign imem_rd   = fetch_go;
  assign halted    = (upc == US_HALT);
endmodule

// File: rtl/ucpu_chk.sv
module ucpu_chk #(
  parameter logic [15:0] PC_STEP = 16'd2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        imem_rd,
  input logic [15:0] imem_addr,
  input logic        halted,
  input logic        rf_we
);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!imem_rd && !rf_we));

  // R9
  halt_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr));

  // R6
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> (imem_addr == $past(imem_addr) + PC_STEP));

  // R7
  decode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> (!imem_rd && !rf_we));

  // R7
  exec_fetches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> imem_rd);
endmodule

bind ucpu_top ucpu_chk #(.PC_STEP(PC_STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_rd   (imem_rd),
  .imem_addr (imem_addr),
  .halted    (halted),
  .rf_we     (rf_we)
);

// File: tb/sim_ucpu_top.sv
module sim_ucpu_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr;
  logic        imem_rd;
  logic [15:0] imem_rdata = '0;
  logic [3:0]  dbg_sel = '0;
  logic [15:0] dbg_data;
  logic        halted;

  logic [15:0] mem [MEM_WORDS];
  logic [15:0] model [16];
  int          n_checks = 0;
  int          n_errors = 0;
  int          cycles = 0;

  ucpu_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rd    (imem_rd),
    .imem_rdata (imem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data),
    .halted     (halted)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // registered-read instruction memory
  always @(posedge clk) begin
    if (imem_rd) imem_rdata <= mem[imem_addr[6:1]];
  end

  function automatic logic [15:0] seed_of(int k);
    return 16'h0005 + 16'(k) * 16'h0123;
  endfunction

  function automatic logic [15:0] enc(logic [7:0] op, int y, int x);
    return {op, 4'(y), 4'(x)};
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'hFF00;
  endtask

  // sequential interpretation of the first n words: R2 fields, R3 R4 R5 semantics
  task automatic run_model(int n);
    for (int k = 0; k < 16; k++) model[k] = seed_of(k);
    for (int i = 0; i < n; i++) begin
      logic [7:0]  op;
      int          y, x;
      op = mem[i][15:8];
      y  = int'(mem[i][7:4]);
      x  = int'(mem[i][3:0]);
      case (op)
        8'h01:   model[y] = model[x];
        8'h02:   model[y] = model[y] + model[x];
        8'h03:   model[y] = model[y] & model[x];
        default: ;
      endcase
    end
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < 16; k++) begin
      dbg_sel = 4'(k);
      #1;
      check(dbg_data === model[k], req, dbg_data, model[k]);
    end
  endtask

  // reset, run n valid words plus the invalid one that follows, compare
  task automatic run_prog(int n, string req);
    int edges;
    int rd_seen;
    logic [15:0] addr_at_halt;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(imem_addr === 16'h0000, "R1 addr", imem_addr, 16'h0000);
    check(imem_rd === 1'b1, "R1 rd", 16'(imem_rd), 16'h0001);
    check(halted === 1'b0, "R1 halted", 16'(halted), 16'h0000);
    for (int k = 0; k < 16; k++) model[k] = seed_of(k);
    check_regs("R1 seed");
    rst_n = 1'b1;
    edges = 0;
    while (edges < 200) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (halted) break;
    end
    // R7 two cycles per instruction, fetch overlapped with execute
    check(edges == 2 * n + 2, "R7 cycles", 16'(edges), 16'(2 * n + 2));
    // R6 program counter after N+1 fetches
    check(imem_addr === 16'(2 * (n + 1)), "R6 pc", imem_addr, 16'(2 * (n + 1)));
    run_model(n);
    check_regs(req);
    // R9 everything frozen in halt
    addr_at_halt = imem_addr;
    rd_seen = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (imem_rd) rd_seen++;
    end
    check(rd_seen == 0, "R9 no reads", 16'(rd_seen), 16'h0000);
    check(imem_addr === addr_at_halt, "R9 addr hold", imem_addr, addr_at_halt);
    check(halted === 1'b1, "R9 halted", 16'(halted), 16'h0001);
    check_regs("R9 regs hold");
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < 16; k++) model[k] = '0;

    // R3 R4 R5 R8: dependent chain, Ry equal to Rx
    clear_mem();
    mem[0] = enc(8'h01, 1, 2);
    mem[1] = enc(8'h02, 1, 1);
    mem[2] = enc(8'h03, 3, 1);
    mem[3] = enc(8'h02, 1, 3);
    mem[4] = enc(8'h01, 0, 1);
    run_prog(5, "R8 chain");

    // R9: invalid opcode 0x00 as the very first word
    clear_mem();
    mem[0] = enc(8'h00, 4, 5);
    run_prog(0, "R9 first");

    // R9: opcode 0x04 after two valid words, later words must not execute
    clear_mem();
    mem[0] = enc(8'h02, 6, 7);
    mem[1] = enc(8'h03, 7, 9);
    mem[2] = enc(8'h04, 6, 6);
    mem[3] = enc(8'h01, 6, 0);
    run_prog(2, "R9 stop");

    // R4: wrap modulo 2^16 by repeated doubling of R15
    clear_mem();
    for (int i = 0; i < 6; i++) mem[i] = enc(8'h02, 15, 15);
    mem[6] = enc(8'h02, 14, 15);
    run_prog(7, "R4 wrap");

    // R2 R3 R4 R5 R10: random programs of the three defined opcodes
    for (int t = 0; t < 5; t++) begin
      clear_mem();
      for (int i = 0; i < 40; i++)
        mem[i] = enc(8'($urandom_range(3, 1)), int'($urandom_range(15, 0)),
                     int'($urandom_range(15, 0)));
      run_prog(40, "R2 R3 R4 R5 R10 random");
    end

    finish_run();
  end
endmodule